// File: doc/BRIEF.md
# Carrier Phase Tracking Loop

This block removes the residual carrier phase and frequency offset from a stream of complex baseband samples in a BPSK or QPSK receiver. Every accepted I/Q pair is rotated by the negative of the angle held in a phase accumulator. A decision-directed detector then turns the rotated pair into an error value. That error feeds a proportional-plus-integral filter, and the filter output advances the accumulator. The top bits of the accumulator index a folded quarter-wave sine table whose sine and cosine feed the rotator. The loop is therefore closed.

The bandwidth and damping of the loop are set by two right-shift amounts: one for the proportional path and one for the integral path. The integral register is the loop's estimate of the frequency offset, and it is brought out as a port. A synchronous clear restarts the acquisition from zero phase and zero frequency. The detector law is chosen by a mode input, either BPSK or QPSK.

Top module: `carrier_track`

## Requirements
- R1: `outValid` is high in the cycle after a cycle where `inValid` is high and `clear` is low, and low otherwise. `outI`/`outQ` keep their values when no sample is accepted.
- R2: For a sample accepted with accumulator value P, the outputs are `outI = (I*c + Q*s) >>> (TRIG_W-1)` and `outQ = (Q*c - I*s) >>> (TRIG_W-1)`. Here s and c are the table sine and cosine at P, and the shift rounds toward minus infinity.
- R3: The table angle for the top ADDR_W bits `a` of the accumulator is 2π(a+0.5)/2^ADDR_W. Each value is the sine or cosine times 2^(TRIG_W-1)-1, with the magnitude rounded to the nearest integer and the sign applied afterwards.
- R4: With `qpskMode`=1, the error is sgn(outI)·outQ − sgn(outQ)·outI, where sgn(x) is −1 for x<0 and +1 otherwise (zero counts as positive).
- R5: With `qpskMode`=0, the error is sgn(outI)·outQ.
- R6: In the cycle where `outValid` is high and `clear` is low, the integrator `freqEst` takes the value `freqEst + (err >>> intShift)`. The result saturates at −2^(INT_W-1) and 2^(INT_W-1)−1 instead of wrapping.
- R7: In the same cycle, `phase` advances by `(err >>> propShift)` plus the updated integrator, modulo 2^PH_W.
- R8: While `clear` is high, the next edge sets `phase` and `freqEst` to zero, drops any sample presented, and cancels the pending loop update.
- R9: After reset, `outValid`, `outI`, `outQ`, `phase` and `freqEst` are all zero.
- R10: In a cycle with neither a loop update nor a clear, `phase` and `freqEst` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart of phase and integrator |
| inValid | input | 1 | Sample strobe |
| inI | input | SAMPLE_W | In-phase sample, signed |
| inQ | input | SAMPLE_W | Quadrature sample, signed |
| qpskMode | input | 1 | 1 selects the QPSK detector, 0 selects BPSK |
| propShift | input | SHIFT_W | Right shift of the proportional path |
| intShift | input | SHIFT_W | Right shift of the integral path |
| outValid | output | 1 | Corrected sample strobe |
| outI | output | SAMPLE_W+1 | De-rotated in-phase sample, signed |
| outQ | output | SAMPLE_W+1 | De-rotated quadrature sample, signed |
| phase | output | PH_W | Phase accumulator |
| freqEst | output | INT_W | Integrator (frequency estimate), signed |

## Verification
The bench builds the block with 10-bit samples, 10-bit trigonometric values, a 16-bit accumulator, an 8-bit table address and a narrowed 12-bit integrator. With this narrow integrator, shift settings of zero drive the frequency estimate into both saturation limits within a few hundred random samples. The full 256-entry angle range is exercised through the fast-spinning accumulator. The QPSK and BPSK detector laws are both covered, as are back-to-back and gapped sample strobes, a clear that arrives during a pending update, and long idle stretches.

// File: rtl/crl_pkg.sv
`timescale 1ns/1ps
package crl_pkg;
  typedef struct packed {
    logic capture;  // latch a de-rotated sample
    logic update;   // advance filter and accumulator
    logic wipe;     // zero filter and accumulator
  } crl_strobe_t;
endpackage

// File: rtl/crl_sincos.sv
`timescale 1ns/1ps
module crl_sincos #(
  parameter int ADDR_W = 8,
  parameter int TRIG_W = 10
) (
  input  logic        [ADDR_W-1:0] addr,
  output logic signed [TRIG_W-1:0] sinV,
  output logic signed [TRIG_W-1:0] cosV
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int QUART = 1 << IDX_W;
  localparam int AMP   = (1 << (TRIG_W - 1)) - 1;

  // Quarter-wave magnitude at bin centre, Taylor series evaluated at elaboration
  function automatic int quarterVal(input int j);
    real x, term, acc;
    x = 2.0 * 3.14159265358979323846 * (real'(j) + 0.5) / real'(1 << ADDR_W);
    term = x;
    acc = x;
    for (int n = 1; n <= 9; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc = acc + term;
    end
    return $rtoi(real'(AMP) * acc + 0.5);
  endfunction

  logic signed [TRIG_W-1:0] qtab [QUART];
  logic signed [TRIG_W-1:0] trig [2];

  for (genvar j = 0; j < QUART; j++) begin : g_tab
    assign qtab[j] = TRIG_W'(quarterVal(j));
  end

  // lane 0 = sine, lane 1 = cosine (address advanced by a quarter turn)
  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic        [ADDR_W-1:0] laneAddr;
    logic        [IDX_W-1:0]  idx;
    logic signed [TRIG_W-1:0] mag;
    assign laneAddr = addr + ADDR_W'(k * QUART);
    assign idx      = laneAddr[ADDR_W-2] ? ~laneAddr[IDX_W-1:0] : laneAddr[IDX_W-1:0];
    assign mag      = qtab[idx];
    assign trig[k]  = laneAddr[ADDR_W-1] ? -mag : mag;
  end

  assign sinV = trig[0];
  assign cosV = trig[1];
endmodule

// File: rtl/crl_ctrl.sv
`timescale 1ns/1ps
module crl_ctrl
  import crl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        inValid,
  output crl_strobe_t stb,
  output logic        outValid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid & ~clear;
  end

  assign stb.capture = inValid & ~clear;
  assign stb.update  = outValid & ~clear;
  assign stb.wipe    = clear;

  // R1: an accepted sample shows up one cycle later
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !clear) |=> outValid);

  // R8: update and wipe never coincide
  p_update_wipe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.update, clear}));
endmodule

// File: rtl/crl_datapath.sv
`timescale 1ns/1ps
module crl_datapath
  import crl_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int TRIG_W   = 10,
  parameter int PH_W     = 16,
  parameter int ADDR_W   = 8,
  parameter int INT_W    = 16,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  crl_strobe_t                stb,
  input  logic signed [SAMPLE_W-1:0] inI,
  input  logic signed [SAMPLE_W-1:0] inQ,
  input  logic                       qpskMode,
  input  logic        [SHIFT_W-1:0]  propShift,
  input  logic        [SHIFT_W-1:0]  intShift,
  output logic signed [SAMPLE_W:0]   outI,
  output logic signed [SAMPLE_W:0]   outQ,
  output logic        [PH_W-1:0]     phaseAcc,
  output logic signed [INT_W-1:0]    integ
);
  localparam int OUT_W  = SAMPLE_W + 1;
  localparam int ERR_W  = SAMPLE_W + 3;
  localparam int WIDE_W = 32;
  localparam int FRAC   = TRIG_W - 1;
  localparam int IntHi  = (1 << (INT_W - 1)) - 1;
  localparam int IntLo  = -(1 << (INT_W - 1));

  logic signed [TRIG_W-1:0] sinV, cosV;
  logic signed [OUT_W-1:0]  rotI, rotQ;
  logic signed [ERR_W-1:0]  exI, exQ, termA, termB, phErr;
  logic signed [WIDE_W-1:0] intSum, steer;
  logic signed [INT_W-1:0]  intNext;
  logic        [PH_W-1:0]   phaseNext;

  crl_sincos #(.ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) sincos_i (
    .addr (phaseAcc[PH_W-1 -: ADDR_W]),
    .sinV (sinV),
    .cosV (cosV)
  );

  // De-rotation by the negative of the accumulator angle
  always_comb begin
    rotI = OUT_W'((WIDE_W'(inI) * WIDE_W'(cosV) + WIDE_W'(inQ) * WIDE_W'(sinV)) >>> FRAC);
    rotQ = OUT_W'((WIDE_W'(inQ) * WIDE_W'(cosV) - WIDE_W'(inI) * WIDE_W'(sinV)) >>> FRAC);
  end

  // Decision-directed detector on the registered corrected sample
  always_comb begin
    exI   = ERR_W'(outI);
    exQ   = ERR_W'(outQ);
    termA = outI[OUT_W-1] ? -exQ : exQ;
    termB = outQ[OUT_W-1] ? -exI : exI;
    phErr = qpskMode ? (termA - termB) : termA;
  end

  // Proportional-plus-integral filter and accumulator step
  always_comb begin
    intSum = WIDE_W'(integ) + (WIDE_W'(phErr) >>> intShift);
    if (intSum > IntHi)      intNext = INT_W'(IntHi);
    else if (intSum < IntLo) intNext = INT_W'(IntLo);
    else                     intNext = INT_W'(intSum);
    steer     = (WIDE_W'(phErr) >>> propShift) + WIDE_W'(intNext);
    phaseNext = phaseAcc + PH_W'(steer);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outI <= '0;
      outQ <= '0;
    end else if (stb.capture) begin
      outI <= rotI;
      outQ <= rotQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
      integ    <= '0;
    end else if (stb.wipe) begin
      phaseAcc <= '0;
      integ    <= '0;
    end else if (stb.update) begin
      phaseAcc <= phaseNext;
      integ    <= intNext;
    end
  end

  // R1: outputs hold without an accepted sample
  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> ($stable(outI) && $stable(outQ)));

  // R8: clear leaves phase and integrator at zero
  p_wipe_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wipe |=> (phaseAcc == '0 && integ == '0));

  // R10: loop state holds between updates
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.update && !stb.wipe) |=> ($stable(phaseAcc) && $stable(integ)));

  // R6: integrator pinned at its upper limit by a non-negative error
  p_sat_top_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.update && !stb.wipe && integ == INT_W'(IntHi) && !phErr[ERR_W-1])
      |=> integ == INT_W'(IntHi));

  // R6: integrator pinned at its lower limit by a non-positive error
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.update && !stb.wipe && integ == INT_W'(IntLo) && (phErr[ERR_W-1] || phErr == '0))
      |=> integ == INT_W'(IntLo));
endmodule

// File: rtl/carrier_track.sv
`timescale 1ns/1ps
module carrier_track
  import crl_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int TRIG_W   = 10,
  parameter int PH_W     = 16,
  parameter int ADDR_W   = 8,
  parameter int INT_W    = 16,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clear,
  input  logic                       inValid,
  input  logic signed [SAMPLE_W-1:0] inI,
  input  logic signed [SAMPLE_W-1:0] inQ,
  input  logic                       qpskMode,
  input  logic        [SHIFT_W-1:0]  propShift,
  input  logic        [SHIFT_W-1:0]  intShift,
  output logic                       outValid,
  output logic signed [SAMPLE_W:0]   outI,
  output logic signed [SAMPLE_W:0]   outQ,
  output logic        [PH_W-1:0]     phase,
  output logic signed [INT_W-1:0]    freqEst
);
  crl_strobe_t stb;

  crl_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .clear    (clear),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  crl_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .TRIG_W   (TRIG_W),
    .PH_W     (PH_W),
    .ADDR_W   (ADDR_W),
    .INT_W    (INT_W),
    .SHIFT_W  (SHIFT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inI       (inI),
    .inQ       (inQ),
    .qpskMode  (qpskMode),
    .propShift (propShift),
    .intShift  (intShift),
    .outI      (outI),
    .outQ      (outQ),
    .phaseAcc  (phase),
    .integ     (freqEst)
  );
endmodule

// File: tb/carrier_track_tb.sv
`timescale 1ns/1ps
module carrier_track_tb_top;
  localparam int SW = 10;
  localparam int TW = 10;
  localparam int PW = 16;
  localparam int AW = 8;
  localparam int IW = 12;
  localparam int HW = 4;
  localparam int OW = SW + 1;
  localparam int AMP = (1 << (TW - 1)) - 1;
  localparam int QUART = 1 << (AW - 2);
  localparam int IMAX = (1 << (IW - 1)) - 1;
  localparam int IMIN = -(1 << (IW - 1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic inValid = 1'b0;
  logic qpskMode = 1'b1;
  logic signed [SW-1:0] inI = '0;
  logic signed [SW-1:0] inQ = '0;
  logic [HW-1:0] propShift = '0;
  logic [HW-1:0] intShift = '0;
  logic outValid;
  logic signed [OW-1:0] outI, outQ;
  logic [PW-1:0] phase;
  logic signed [IW-1:0] freqEst;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;
  bit sawTop = 0;
  bit sawBot = 0;
  string outTag = "R2";
  string loopTag = "R7";

  // model state
  int mPh = 0, mInt = 0, mOI = 0, mOQ = 0;
  bit mOV = 0;

  carrier_track #(.SAMPLE_W(SW), .TRIG_W(TW), .PH_W(PW), .ADDR_W(AW),
                  .INT_W(IW), .SHIFT_W(HW)) dut_i (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid),
    .inI(inI), .inQ(inQ), .qpskMode(qpskMode), .propShift(propShift),
    .intShift(intShift), .outValid(outValid), .outI(outI), .outQ(outQ),
    .phase(phase), .freqEst(freqEst)
  );

  always #2 clk = ~clk;

  function automatic int trigVal(input int a);
    real x, s;
    int m;
    x = 2.0 * 3.14159265358979323846 * (real'(a & ((1 << AW) - 1)) + 0.5) / real'(1 << AW);
    s = $sin(x);
    m = $rtoi(real'(AMP) * (s < 0.0 ? -s : s) + 0.5);
    return (s < 0.0) ? -m : m;
  endfunction

  function automatic int detErr(input int i, input int q, input bit qp);
    int si, sq;
    si = (i < 0) ? -1 : 1;
    sq = (q < 0) ? -1 : 1;
    return qp ? (si * q - sq * i) : (si * q);
  endfunction

  function automatic int clampInt(input int v);
    if (v > IMAX) return IMAX;
    if (v < IMIN) return IMIN;
    return v;
  endfunction

  task automatic modelEdge();
    bit nv;
    int a, s, c, nI, nQ, e;
    nv = inValid && !clear;
    a = (mPh >> (PW - AW)) & ((1 << AW) - 1);
    s = trigVal(a);
    c = trigVal(a + QUART);
    nI = (int'(inI) * c + int'(inQ) * s) >>> (TW - 1);
    nQ = (int'(inQ) * c - int'(inI) * s) >>> (TW - 1);
    if (clear) begin
      mPh = 0;
      mInt = 0;
    end else if (mOV) begin
      e = detErr(mOI, mOQ, qpskMode);
      mInt = clampInt(mInt + (e >>> intShift));
      mPh = (mPh + (e >>> propShift) + mInt) & ((1 << PW) - 1);
    end
    if (nv) begin
      mOI = nI;
      mOQ = nQ;
    end
    mOV = nv;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check("R1", "outValid", int'(outValid), int'(mOV));
    check(outTag, "outI", int'(outI), mOI);
    check(outTag, "outQ", int'(outQ), mOQ);
    check(loopTag, "phase", int'(phase), mPh);
    check(loopTag == "R7" ? "R6" : loopTag, "freqEst", int'(freqEst), mInt);
    if (int'(freqEst) == IMAX) sawTop = 1;
    if (int'(freqEst) == IMIN) sawBot = 1;
  endtask

  task automatic cyc();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic drive(input bit v, input int i, input int q);
    inValid = v;
    inI = SW'(i);
    inQ = SW'(q);
  endtask

  task automatic randomRun(input int n, input int validPct);
    for (int k = 0; k < n; k++) begin
      drive(($urandom % 100) < validPct,
            int'($urandom % (1 << SW)) - (1 << (SW - 1)),
            int'($urandom % (1 << SW)) - (1 << (SW - 1)));
      cyc();
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "outValid", int'(outValid), 0);
    check("R9", "outI", int'(outI), 0);
    check("R9", "outQ", int'(outQ), 0);
    check("R9", "phase", int'(phase), 0);
    check("R9", "freqEst", int'(freqEst), 0);
    rstN = 1'b1;

    // R3: known rotation at zero phase, loop nearly frozen
    outTag = "R3";
    propShift = 4'd15; intShift = 4'd15; qpskMode = 1'b1;
    drive(1, 500, 0); cyc();
    check("R3", "outI at phase 0", int'(outI), (500 * trigVal(QUART)) >>> (TW - 1));
    check("R3", "outQ at phase 0", int'(outQ), -((500 * trigVal(0) + (1 << (TW - 1)) - 1) >>> (TW - 1)));
    drive(1, -300, 200); cyc();
    drive(0, 0, 0); cyc();

    // R4: QPSK detector, moderate gains, mixed strobes
    outTag = "R2"; loopTag = "R4";
    qpskMode = 1'b1; propShift = 4'd3; intShift = 4'd7;
    randomRun(400, 70);

    // R5: BPSK detector, back-to-back samples
    loopTag = "R5";
    qpskMode = 1'b0; propShift = 4'd2; intShift = 4'd6;
    randomRun(400, 100);

    // R6: large integral gain drives both saturation limits
    loopTag = "R7";
    qpskMode = 1'b1; propShift = 4'd0; intShift = 4'd0;
    sawTop = 0; sawBot = 0;
    randomRun(1500, 90);
    check("R6", "upper limit reached", int'(sawTop), 1);
    check("R6", "lower limit reached", int'(sawBot), 1);

    // R8: clear while an update is pending and a sample is offered
    propShift = 4'd3; intShift = 4'd5;
    randomRun(20, 100);
    drive(1, 123, -77); clear = 1'b1; cyc();
    check("R8", "phase after clear", int'(phase), 0);
    check("R8", "freqEst after clear", int'(freqEst), 0);
    check("R8", "sample dropped", int'(outValid), 0);
    clear = 1'b0; drive(0, 0, 0); cyc();
    check("R8", "phase stays zero", int'(phase), 0);

    // R10: idle stretch holds loop state
    randomRun(30, 100);
    loopTag = "R10";
    drive(0, 0, 0);
    cyc();
    for (int k = 0; k < 25; k++) cyc();

    // final mixed run
    loopTag = "R7";
    qpskMode = 1'b1; propShift = 4'd4; intShift = 4'd8;
    randomRun(300, 50);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule